// File: doc/BRIEF.md
# Gamma Curve Slope Encoder Loader

This block takes a gamma curve as a stream of 10-bit RGB points and turns it into the register writes for a gamma table that extrapolates. Each table entry holds one point's 10-bit value and a small floating-point slope toward the next point. The table never stores the last point explicitly. That point is implied by the previous entry's value plus its slope. To compute a slope the block must see the following point, so it keeps one point of lookahead.

Each curve interval produces two words. The first word holds the low eight value bits of every channel. The second word holds, per channel, a 2-bit exponent, a 4-bit mantissa and the top two value bits. The first point of a curve produces no write. Every later point closes one interval and triggers one even/odd write pair.

After the final point the block pulses `done`. Together with `done` it reports `err` when the last interval rises too steeply to be represented.

Input back-pressure: a point moves only on a cycle where `pt_valid` and `pt_ready` are both high. The block holds `pt_ready` low while it emits a pair of words and during the `done` cycle. A source may keep `pt_valid` high with stable data for as long as `pt_ready` is low. The write side has no back-pressure: `wr_en` is a one-cycle strobe.

Top module: `gamma_slope_loader`

## Requirements
- R1: `pt_ready` is high whenever the block is idle waiting for a point. It is low in every cycle where `wr_en` or `done` is high.
- R2: The first point of a curve causes no write. Each later accepted point causes exactly two writes on the two cycles right after it is accepted: the even word first, then the odd word.
- R3: Interval i of a curve (i counted from 0) is written at word address 2i for the even word and 2i+1 for the odd word. A new curve starts again at address 0.
- R4: The even word of interval i carries the low eight bits of point i. Red is at bits 23:16, green at 15:8 and blue at 7:0. Input points are packed as red 29:20, green 19:10, blue 9:0.
- R5: The odd word uses the same channel byte positions as the even word. Within each byte, bits 7:6 are the exponent, bits 5:2 the mantissa, and bits 1:0 are bits 9:8 of point i.
- R6: The per-channel delta is point i+1 minus point i, clamped to 0..127. A falling channel gives a zero slope (exponent 3, mantissa 0).
- R7: The slope code starts with exponent 3 and mantissa equal to the clamped delta. While the mantissa is above 15, it is halved (right shift) and the exponent is lowered by one.
- R8: `done` is a single-cycle pulse in the cycle after the curve's final odd write. `err` is never high outside a `done` cycle.
- R9: `err` is high with `done` exactly when some channel's final-interval delta exceeds 127. Steep or falling earlier intervals never raise `err`.
- R10: A curve made of a single point (first point flagged last) produces no write and a `done` pulse with `err` low.
- R11: After reset `pt_ready` is high, and `wr_en`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pt_valid | input | 1 | Curve point offered |
| pt_ready | output | 1 | Block can take a point this cycle |
| pt_last | input | 1 | Offered point is the last of its curve |
| pt_data | input | 30 | Point value: red 29:20, green 19:10, blue 9:0 |
| wr_en | output | 1 | Table write strobe |
| wr_addr | output | 8 | Table word address |
| wr_data | output | 24 | Table word data |
| done | output | 1 | Curve finished (one-cycle pulse) |
| err | output | 1 | Final interval too steep, valid with done |

## Verification
The bench targets the exponent boundaries at deltas 15/16, 31/32, 63/64 and 127/128. A normaliser that shifts once too often or too seldom shows up there as a wrong exponent or mantissa. Falling channels are checked for a zero slope: a design that wraps the subtraction instead of clamping writes a large slope. Steep intervals placed in the middle of a curve must not raise `err`, while a final delta of exactly 127 must pass and one of 128 must fail. A one-point curve must finish with no writes at all, and addresses must restart at zero for each new curve.

// File: rtl/gsl_pkg.sv
package gsl_pkg;
  localparam int unsigned GSL_CH_W   = 10;
  localparam int unsigned GSL_LOW_W  = 8;
  localparam int unsigned GSL_EXP_W  = 2;
  localparam int unsigned GSL_MANT_W = 4;
  localparam int unsigned GSL_NUM_CH = 3;
  localparam int unsigned GSL_NUM_PT = 129;

  typedef enum logic [1:0] {
    GS_ACCEPT = 2'd0,
    GS_EVEN   = 2'd1,
    GS_ODD    = 2'd2,
    GS_DONE   = 2'd3
  } gsl_state_e;
endpackage

// File: rtl/gsl_slope_enc.sv
module gsl_slope_enc
  import gsl_pkg::*;
#(
  parameter int unsigned CH_W   = GSL_CH_W,
  parameter int unsigned EXP_W  = GSL_EXP_W,
  parameter int unsigned MANT_W = GSL_MANT_W
) (
  input  logic [CH_W-1:0]         cur_val,
  input  logic [CH_W-1:0]         nxt_val,
  output logic [EXP_W+MANT_W-1:0] slope_code,
  output logic                    too_steep
);
  localparam int unsigned EXP_MAX   = (1 << EXP_W) - 1;
  localparam int unsigned MANT_MAX  = (1 << MANT_W) - 1;
  localparam int unsigned DELTA_MAX = ((MANT_MAX + 1) << EXP_MAX) - 1;
  localparam int unsigned DW        = $clog2(DELTA_MAX + 1);
  localparam logic signed [CH_W:0] LIM_S = (CH_W+1)'(DELTA_MAX);

  logic signed [CH_W:0] diff;
  logic [DW-1:0]        clamped;
  logic [DW-1:0]        mant;
  logic [EXP_W-1:0]     expo;

  assign diff = $signed({1'b0, nxt_val}) - $signed({1'b0, cur_val});

  always_comb begin
    if (diff < 0)          clamped = '0;
    else if (diff > LIM_S) clamped = DW'(DELTA_MAX);
    else                   clamped = diff[DW-1:0];
  end

  assign too_steep = (diff > LIM_S);

  always_comb begin
    mant = clamped;
    expo = EXP_W'(EXP_MAX);
    for (int k = 0; k < int'(EXP_MAX); k++) begin
      if (mant > DW'(MANT_MAX)) begin
        mant = mant >> 1;
        expo = expo - 1'b1;
      end
    end
  end

  assign slope_code = {expo, mant[MANT_W-1:0]};

  always_comb begin
    AST_MANT_FITS: assert (mant <= DW'(MANT_MAX)); // R7
    AST_NORMALISED: assert ((expo == EXP_W'(EXP_MAX)) || mant[MANT_W-1]); // R7
  end
endmodule

// File: rtl/gsl_word_pack.sv
module gsl_word_pack
  import gsl_pkg::*;
#(
  parameter int unsigned CH_W   = GSL_CH_W,
  parameter int unsigned LOW_W  = GSL_LOW_W,
  parameter int unsigned NUM_CH = GSL_NUM_CH,
  parameter int unsigned SL_W   = GSL_EXP_W + GSL_MANT_W
) (
  input  logic [NUM_CH*CH_W-1:0]  cur_pt,
  input  logic [NUM_CH*SL_W-1:0]  slopes,
  output logic [NUM_CH*LOW_W-1:0] even_word,
  output logic [NUM_CH*LOW_W-1:0] odd_word
);
  localparam int unsigned HI_W = CH_W - LOW_W;

  for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_ch
    localparam int unsigned POS = NUM_CH - 1 - c;
    logic [CH_W-1:0] val;
    assign val = cur_pt[POS*CH_W +: CH_W];
    assign even_word[POS*LOW_W +: LOW_W] = val[LOW_W-1:0];
    assign odd_word[POS*LOW_W +: LOW_W]  = {slopes[POS*SL_W +: SL_W], val[CH_W-1 -: HI_W]};
  end
endmodule

// File: rtl/gsl_ctrl.sv
module gsl_ctrl
  import gsl_pkg::*;
#(
  parameter int unsigned PT_W   = GSL_NUM_CH * GSL_CH_W,
  parameter int unsigned WORD_W = GSL_NUM_CH * GSL_LOW_W,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pt_valid,
  input  logic              pt_last,
  input  logic [PT_W-1:0]   pt_data,
  output logic              pt_ready,
  output logic [PT_W-1:0]   prev_pt,
  input  logic [WORD_W-1:0] even_w,
  input  logic [WORD_W-1:0] odd_w,
  input  logic              steep_any,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              done,
  output logic              err
);
  localparam int unsigned IDX_W = ADDR_W - 1;

  gsl_state_e        state_q;
  logic              have_prev_q;
  logic              last_q;
  logic              err_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] even_q;
  logic [WORD_W-1:0] odd_q;
  logic [PT_W-1:0]   prev_q;
  logic              accept;

  assign pt_ready = (state_q == GS_ACCEPT);
  assign accept   = pt_valid & pt_ready;
  assign prev_pt  = prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= GS_ACCEPT;
      have_prev_q <= 1'b0;
      last_q      <= 1'b0;
      err_q       <= 1'b0;
      idx_q       <= '0;
      even_q      <= '0;
      odd_q       <= '0;
      prev_q      <= '0;
    end else begin
      unique case (state_q)
        GS_ACCEPT: begin
          if (accept) begin
            prev_q <= pt_data;
            if (have_prev_q) begin
              even_q  <= even_w;
              odd_q   <= odd_w;
              last_q  <= pt_last;
              err_q   <= pt_last & steep_any;
              state_q <= GS_EVEN;
            end else if (pt_last) begin
              err_q   <= 1'b0;
              state_q <= GS_DONE;
            end else begin
              have_prev_q <= 1'b1;
            end
          end
        end
        GS_EVEN: state_q <= GS_ODD;
        GS_ODD: begin
          if (last_q) begin
            idx_q       <= '0;
            have_prev_q <= 1'b0;
            state_q     <= GS_DONE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= GS_ACCEPT;
          end
        end
        GS_DONE: state_q <= GS_ACCEPT;
        default: state_q <= GS_ACCEPT;
      endcase
    end
  end

  assign wr_en   = (state_q == GS_EVEN) || (state_q == GS_ODD);
  assign wr_addr = {idx_q, (state_q == GS_ODD)};
  assign wr_data = (state_q == GS_ODD) ? odd_q : even_q;
  assign done    = (state_q == GS_DONE);
  assign err     = done & err_q;

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || done) |-> !pt_ready); // R1
  AST_ODD_AFTER_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr[0]) |=> (wr_en && wr_addr[0] &&
      wr_addr[ADDR_W-1:1] == $past(wr_addr[ADDR_W-1:1]))); // R2
  AST_ODD_HAS_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[0]) |-> $past(wr_en && !wr_addr[0])); // R2
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_NO_WR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    pt_ready |-> !wr_en); // R2
endmodule

// File: rtl/gamma_slope_loader.sv
module gamma_slope_loader
  import gsl_pkg::*;
#(
  parameter int unsigned CH_W   = GSL_CH_W,
  parameter int unsigned LOW_W  = GSL_LOW_W,
  parameter int unsigned EXP_W  = GSL_EXP_W,
  parameter int unsigned MANT_W = GSL_MANT_W,
  parameter int unsigned NUM_CH = GSL_NUM_CH,
  parameter int unsigned NUM_PT = GSL_NUM_PT,
  localparam int unsigned PT_W   = NUM_CH * CH_W,
  localparam int unsigned WORD_W = NUM_CH * LOW_W,
  localparam int unsigned ADDR_W = $clog2(2 * (NUM_PT - 1))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pt_valid,
  output logic              pt_ready,
  input  logic              pt_last,
  input  logic [PT_W-1:0]   pt_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              done,
  output logic              err
);
  localparam int unsigned SL_W = EXP_W + MANT_W;

  logic [PT_W-1:0]        prev_pt;
  logic [NUM_CH*SL_W-1:0] slopes;
  logic [NUM_CH-1:0]      steep_v;
  logic [WORD_W-1:0]      even_w;
  logic [WORD_W-1:0]      odd_w;

  for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_enc
    gsl_slope_enc #(
      .CH_W   (CH_W),
      .EXP_W  (EXP_W),
      .MANT_W (MANT_W)
    ) u_enc (
      .cur_val    (prev_pt[c*CH_W +: CH_W]),
      .nxt_val    (pt_data[c*CH_W +: CH_W]),
      .slope_code (slopes[c*SL_W +: SL_W]),
      .too_steep  (steep_v[c])
    );
  end

  gsl_word_pack #(
    .CH_W   (CH_W),
    .LOW_W  (LOW_W),
    .NUM_CH (NUM_CH),
    .SL_W   (SL_W)
  ) u_pack (
    .cur_pt    (prev_pt),
    .slopes    (slopes),
    .even_word (even_w),
    .odd_word  (odd_w)
  );

  gsl_ctrl #(
    .PT_W   (PT_W),
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .pt_valid  (pt_valid),
    .pt_last   (pt_last),
    .pt_data   (pt_data),
    .pt_ready  (pt_ready),
    .prev_pt   (prev_pt),
    .even_w    (even_w),
    .odd_w     (odd_w),
    .steep_any (|steep_v),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .done      (done),
    .err       (err)
  );
endmodule

// File: tb/tb_gamma_slope_loader.sv
`timescale 1ns/1ps
module tb_gamma_slope_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pt_valid = 1'b0;
  logic        pt_ready;
  logic        pt_last = 1'b0;
  logic [29:0] pt_data = '0;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [23:0] wr_data;
  logic        done;
  logic        err;

  gamma_slope_loader dut (
    .clk(clk), .rst_n(rst_n), .pt_valid(pt_valid), .pt_ready(pt_ready),
    .pt_last(pt_last), .pt_data(pt_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done), .err(err)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int pts_r [0:199];
  int pts_g [0:199];
  int pts_b [0:199];
  int npts;
  int exp_n;
  bit exp_err;
  int cap_n;
  int cap_addr [0:511];
  int cap_data [0:511];
  int done_cnt = 0;
  bit done_err;
  bit prev_odd = 0;
  bit prev_wr = 0;

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int ref_byte_odd(int cur, int nxt);
    int d, e;
    d = nxt - cur;
    if (d < 0) d = 0;
    if (d > 127) d = 127;
    e = 3;
    while (d > 15) begin
      d = d >> 1;
      e = e - 1;
    end
    return (e << 6) | (d << 2) | ((cur >> 8) & 3);
  endfunction

  function automatic int ref_even(int i);
    return ((pts_r[i] & 255) << 16) | ((pts_g[i] & 255) << 8) | (pts_b[i] & 255);
  endfunction

  function automatic int ref_odd(int i);
    return (ref_byte_odd(pts_r[i], pts_r[i+1]) << 16) |
           (ref_byte_odd(pts_g[i], pts_g[i+1]) << 8) |
            ref_byte_odd(pts_b[i], pts_b[i+1]);
  endfunction

  // Monitor: away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (wr_en) begin
        check(!pt_ready, "R1 ready low while writing", int'(pt_ready), 0);
        if (cap_n < 512) begin
          cap_addr[cap_n] = int'(wr_addr);
          cap_data[cap_n] = int'(wr_data);
        end
        cap_n++;
      end
      if (err) check(done, "R8 err outside done", int'(done), 1);
      if (done) begin
        check(!pt_ready, "R1 ready low in done", int'(pt_ready), 0);
        if (exp_n > 0) check(prev_odd, "R8 done right after final odd write", int'(prev_odd), 1);
        else check(!prev_wr, "R10 no write before done", int'(prev_wr), 0);
        done_err = err;
        done_cnt++;
      end
      prev_odd = wr_en && wr_addr[0];
      prev_wr = wr_en;
    end
  end

  task automatic send_point(int i, bit last);
    pt_data = 30'((pts_r[i] << 20) | (pts_g[i] << 10) | pts_b[i]);
    pt_last = last;
    pt_valid = 1'b1;
    while (!pt_ready) @(negedge clk);
    @(negedge clk);
    pt_valid = 1'b0;
    pt_last = 1'b0;
    if (($urandom % 4) == 0) @(negedge clk);
  endtask

  task automatic run_curve(string tag);
    int start, t;
    exp_n = (npts > 1) ? 2 * (npts - 1) : 0;
    exp_err = 0;
    if (npts > 1) begin
      if (pts_r[npts-1] - pts_r[npts-2] > 127) exp_err = 1;
      if (pts_g[npts-1] - pts_g[npts-2] > 127) exp_err = 1;
      if (pts_b[npts-1] - pts_b[npts-2] > 127) exp_err = 1;
    end
    cap_n = 0;
    start = done_cnt;
    check(pt_ready, "R1 ready high when idle", int'(pt_ready), 1);
    for (int i = 0; i < npts; i++) send_point(i, i == npts - 1);
    t = 0;
    while (done_cnt == start && t < 2000) begin
      @(negedge clk);
      t++;
    end
    @(negedge clk);
    check(done_cnt == start + 1, {"R8 one done pulse ", tag}, done_cnt - start, 1);
    check(cap_n == exp_n, {"R2 R10 write count ", tag}, cap_n, exp_n);
    for (int k = 0; k < exp_n && k < cap_n; k++) begin
      check(cap_addr[k] == k, {"R3 address ", tag}, cap_addr[k], k);
      if ((k & 1) == 0)
        check(cap_data[k] == ref_even(k / 2), {"R4 even word ", tag}, cap_data[k], ref_even(k / 2));
      else
        check(cap_data[k] == ref_odd(k / 2), {"R5 R6 R7 odd word ", tag}, cap_data[k], ref_odd(k / 2));
    end
    check(done_err == exp_err, {"R9 final slope error ", tag}, int'(done_err), int'(exp_err));
  endtask

  function automatic int clip(int v);
    if (v < 0) return 0;
    if (v > 1023) return 1023;
    return v;
  endfunction

  // mode 0: rising gently, 1: fully random, 2: rising then steep final step
  task automatic gen_curve(int n, int mode);
    npts = n;
    pts_r[0] = int'($urandom % 64);
    pts_g[0] = int'($urandom % 64);
    pts_b[0] = int'($urandom % 64);
    for (int i = 1; i < n; i++) begin
      if (mode == 1) begin
        pts_r[i] = int'($urandom % 1024);
        pts_g[i] = int'($urandom % 1024);
        pts_b[i] = int'($urandom % 1024);
      end else begin
        pts_r[i] = clip(pts_r[i-1] + int'($urandom % 8));
        pts_g[i] = clip(pts_g[i-1] + int'($urandom % 8));
        pts_b[i] = clip(pts_b[i-1] + int'($urandom % 8));
      end
    end
    if (mode == 2 && n > 1) pts_g[n-1] = pts_g[n-2] + 128 + int'($urandom % 100);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int deltas [0:11];
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R11: reset state
    check(pt_ready == 1'b1, "R11 reset ready", int'(pt_ready), 1);
    check(!wr_en, "R11 reset wr_en", int'(wr_en), 0);
    check(!done && !err, "R11 reset done/err", int'(done) | int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed: exponent boundaries on red, falls on green (R6, R7)
    deltas = '{0, 15, 16, 31, 32, 63, 64, 127, 128, 300, 5, 127};
    npts = 13;
    pts_r[0] = 0; pts_g[0] = 900; pts_b[0] = 256;
    for (int i = 1; i < 13; i++) begin
      pts_r[i] = clip(pts_r[i-1] + deltas[i-1]);
      pts_g[i] = clip(pts_g[i-1] - 60);
      pts_b[i] = pts_b[i-1];
    end
    run_curve("boundaries");

    // Final delta exactly 127: no error (R9)
    npts = 3;
    pts_r[0] = 10; pts_r[1] = 20; pts_r[2] = 147;
    pts_g[0] = 0;  pts_g[1] = 0;  pts_g[2] = 127;
    pts_b[0] = 1000; pts_b[1] = 1023; pts_b[2] = 1023;
    run_curve("final127");

    // Final delta 128: error (R9)
    pts_b[1] = 500; pts_b[2] = 628;
    run_curve("final128");

    // Steep middle, falling final: no error (R9, R6)
    npts = 4;
    pts_r[0] = 0; pts_r[1] = 900; pts_r[2] = 950; pts_r[3] = 10;
    pts_g[0] = 5; pts_g[1] = 6;   pts_g[2] = 7;   pts_g[3] = 8;
    pts_b[0] = 0; pts_b[1] = 1023; pts_b[2] = 1023; pts_b[3] = 1023;
    run_curve("steep_middle");

    // Single point curve (R10)
    npts = 1;
    pts_r[0] = 77; pts_g[0] = 88; pts_b[0] = 99;
    run_curve("single");

    // Two-point curve, address restart (R3)
    gen_curve(2, 0);
    run_curve("two_points");

    // Random full-length curves
    for (int c = 0; c < 6; c++) begin
      gen_curve(129, c % 3);
      run_curve("random_full");
    end
    for (int c = 0; c < 6; c++) begin
      gen_curve(2 + int'($urandom % 20), c % 3);
      run_curve("random_short");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule